// File: doc/BRIEF.md
# Single-to-Half Precision Rounding Converter

This block turns one IEEE-754 binary32 operand into a binary16 value in a single clock cycle. The caller supplies the operand and a two-bit rounding-mode code. The block returns the 16-bit result and four separate exception indications: invalid (signalling NaN), overflow, underflow and inexact. Special operands such as NaNs, infinities and signed zeros pass through their own paths. Finite operands are aligned to the half-precision grid, including the subnormal range, and rounded under the selected mode.

A wider datapath places one copy of the block in each lane. That datapath decides what to do with the flags: it can accumulate them into status or raise traps. With the default parameter the result and flags are registered, so they appear one cycle after the inputs. Setting `REG_OUT` to 0 makes the block purely combinational.

The half-precision layout is a sign bit, a 5-bit exponent with bias 15 in bits 14:10, and a 10-bit fraction in bits 9:0. Flags belong to the result presented in the same cycle.

Top module: `f2h_convert`

## Requirements
- R1: A signalling-NaN operand (exponent all ones, fraction nonzero, fraction bit 22 clear) yields `{sign, 5'h1F, 1'b1, op[21:13]}`. It raises only the invalid flag.
- R2: A quiet-NaN operand (exponent all ones, fraction bit 22 set) yields `{sign, 5'h1F, op[22:13]}`. It raises no flag.
- R3: An infinite operand yields 16'h7C00 carrying the operand's sign. It raises no flag.
- R4: A zero operand yields 16'h0000 carrying the operand's sign. It raises no flag.
- R5: A finite operand that binary16 represents exactly is converted without change in value and raises no flag.
- R6: The rounding-mode code selects the mode: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity. Inexact is raised whenever discarded bits are nonzero.
- R7: When the rounded magnitude reaches exponent 31, the result depends on mode and sign. Nearest gives infinity. Toward zero gives 0x7BFF. Toward +infinity gives infinity for positive and -0x7BFF for negative. Toward -infinity gives the mirror of that. Overflow and inexact are both raised.
- R8: When the value before rounding lies below 2^-14, the result is denormalized with guard, round and sticky bits. Underflow is raised only when that result is also inexact, so an exact tiny result raises no underflow.
- R9: A binary32 subnormal operand is tiny. It yields signed zero, or the signed smallest subnormal 0x0001 when the mode rounds away from zero in its sign direction. It raises underflow and inexact.
- R10: With `REG_OUT`=1, result and flags reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset, clears result and flags |
| op_i | input | 32 | binary32 operand |
| rmode_i | input | 2 | Rounding-mode code (see R6) |
| res_o | output | 16 | binary16 result |
| invalid_o | output | 1 | Signalling-NaN operand seen |
| overflow_o | output | 1 | Rounded result exceeded the finite range |
| underflow_o | output | 1 | Tiny and inexact result |
| inexact_o | output | 1 | Result differs from the operand's value |

## Verification
Every result leaves through the output register one cycle after its operand arrives, so a wrong alignment shift, guard bit or increment decision becomes visible at `res_o` on the very next cycle. It shows up as an off-by-one fraction or a wrong exponent field. A wrong class decode appears as a NaN, infinity or zero pattern in place of a finite result, together with flags that disagree with R1 to R4 in that same cycle. Tie cases, rounding carries into the exponent and the transition from subnormal to normal are driven directly, because a mistake in those places leaves almost every other operand untouched.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

   // source format (binary32)
   localparam int SP_EXP_W  = 8;
   localparam int SP_FRAC_W = 23;
   localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;

   // destination format (binary16)
   localparam int HP_EXP_W  = 5;
   localparam int HP_FRAC_W = 10;
   localparam int HP_W      = 1 + HP_EXP_W + HP_FRAC_W;
   localparam int HP_BIAS   = (1 << (HP_EXP_W - 1)) - 1;
   localparam int HP_EXP_MAX = (1 << HP_EXP_W) - 1;

   // derived alignment constants
   localparam int BIAS_DELTA = SP_BIAS - HP_BIAS;
   localparam int SIG_W      = SP_FRAC_W + 1;
   localparam int DROP_W     = SP_FRAC_W - HP_FRAC_W;
   localparam int PAD_W      = SIG_W + 2;
   localparam int SHIFT_MAX  = PAD_W;
   localparam int SHIFT_W    = $clog2(SHIFT_MAX + 1);
   localparam int EH_W       = SP_EXP_W + 2;
   localparam int MAG_W      = HP_EXP_W + HP_FRAC_W;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_UP        = 2'b10,
      RM_DOWN      = 2'b11
   } rmode_e;

   typedef enum logic [2:0] {
      CL_ZERO,
      CL_INF,
      CL_QNAN,
      CL_SNAN,
      CL_FINITE
   } opclass_e;

   typedef struct packed {
      logic invalid;
      logic overflow;
      logic underflow;
      logic inexact;
   } flags_t;

endpackage

// File: rtl/f2h_unpack.sv
module f2h_unpack
   import f2h_pkg::*;
(
   input  logic [SP_W-1:0]        op,
   output logic                   sign,
   output opclass_e               cls,
   output logic signed [EH_W-1:0] exp_hp,
   output logic [SIG_W-1:0]       sig,
   output logic [HP_FRAC_W-1:0]   nan_frac
);

   logic [SP_EXP_W-1:0]  e_fld;
   logic [SP_FRAC_W-1:0] f_fld;
   logic                 e_ones, e_zero, f_zero;
   logic [SP_EXP_W-1:0]  e_eff;

   assign sign   = op[SP_W-1];
   assign e_fld  = op[SP_W-2 -: SP_EXP_W];
   assign f_fld  = op[SP_FRAC_W-1:0];
   assign e_ones = &e_fld;
   assign e_zero = ~|e_fld;
   assign f_zero = ~|f_fld;

   always_comb begin
      if (e_ones && f_zero)          cls = CL_INF;
      else if (e_ones && f_fld[SP_FRAC_W-1]) cls = CL_QNAN;
      else if (e_ones)               cls = CL_SNAN;
      else if (e_zero && f_zero)     cls = CL_ZERO;
      else                           cls = CL_FINITE;
   end

   // subnormal sources share the minimum exponent and lose the hidden bit
   assign e_eff  = e_zero ? SP_EXP_W'(1) : e_fld;
   assign sig    = {~e_zero, f_fld};
   assign exp_hp = $signed({2'b00, e_eff}) - EH_W'(BIAS_DELTA);

   // top destination-width fraction bits carry the NaN payload
   assign nan_frac = f_fld[SP_FRAC_W-1 -: HP_FRAC_W];

endmodule

// File: rtl/f2h_align_round.sv
module f2h_align_round
   import f2h_pkg::*;
(
   input  logic                   sign,
   input  rmode_e                 rmode,
   input  logic signed [EH_W-1:0] exp_hp,
   input  logic [SIG_W-1:0]       sig,
   output logic [MAG_W-1:0]       mag,
   output logic                   tiny,
   output logic                   ovf,
   output logic                   inx
);

   logic [SHIFT_W-1:0]       shamt;
   logic [SIG_W+PAD_W-1:0]   shifted;
   logic [HP_FRAC_W:0]       kept;
   logic                     guard, sticky, lsb, inc;
   logic                     pre_ovf;
   logic [MAG_W-1:0]         mag_pre;
   logic [MAG_W:0]           sum;

   localparam int TINY_CAP = -(SHIFT_MAX - DROP_W - 1);

   assign tiny    = (exp_hp < EH_W'(1));
   assign pre_ovf = !tiny && (exp_hp >= EH_W'(HP_EXP_MAX));

   always_comb begin
      if (!tiny)
         shamt = SHIFT_W'(DROP_W);
      else if (exp_hp < EH_W'(TINY_CAP))
         shamt = SHIFT_W'(SHIFT_MAX);
      else
         shamt = SHIFT_W'(DROP_W + 1) - SHIFT_W'(exp_hp);
   end

   assign shifted = {sig, PAD_W'(0)} >> shamt;
   assign kept    = shifted[PAD_W+HP_FRAC_W : PAD_W];
   assign guard   = shifted[PAD_W-1];
   // bits above the kept field are zero for every legal shift; folding
   // them into sticky keeps any lost bit visible as inexact
   assign sticky  = (|shifted[PAD_W-2:0]) | (|shifted[SIG_W+PAD_W-1 : PAD_W+HP_FRAC_W+1]);
   assign lsb     = kept[0];
   assign inx     = guard | sticky;

   always_comb begin
      unique case (rmode)
         RM_NEAR_EVEN: inc = guard & (sticky | lsb);
         RM_TO_ZERO:   inc = 1'b0;
         RM_UP:        inc = !sign & inx;
         RM_DOWN:      inc = sign & inx;
         default:      inc = 1'b0;
      endcase
   end

   assign mag_pre = tiny ? {HP_EXP_W'(0), kept[HP_FRAC_W-1:0]}
                         : {exp_hp[HP_EXP_W-1:0], kept[HP_FRAC_W-1:0]};
   assign sum     = {1'b0, mag_pre} + (MAG_W+1)'(inc);
   assign mag     = sum[MAG_W-1:0];
   assign ovf     = pre_ovf | (&sum[MAG_W-1 -: HP_EXP_W]) | sum[MAG_W];

endmodule

// File: rtl/f2h_select.sv
module f2h_select
   import f2h_pkg::*;
(
   input  logic                 sign,
   input  opclass_e             cls,
   input  rmode_e               rmode,
   input  logic [HP_FRAC_W-1:0] nan_frac,
   input  logic [MAG_W-1:0]     mag,
   input  logic                 tiny,
   input  logic                 ovf,
   input  logic                 inx,
   output logic [HP_W-1:0]      res,
   output flags_t               flags
);

   localparam logic [MAG_W-1:0] MAG_INF = {HP_EXP_W'(HP_EXP_MAX), HP_FRAC_W'(0)};
   localparam logic [MAG_W-1:0] MAG_MAX = MAG_INF - MAG_W'(1);

   logic            sat_to_inf;
   logic [MAG_W-1:0] ovf_mag;
   logic [HP_FRAC_W-1:0] quiet_frac;

   always_comb begin
      unique case (rmode)
         RM_NEAR_EVEN: sat_to_inf = 1'b1;
         RM_TO_ZERO:   sat_to_inf = 1'b0;
         RM_UP:        sat_to_inf = !sign;
         RM_DOWN:      sat_to_inf = sign;
         default:      sat_to_inf = 1'b1;
      endcase
   end

   assign ovf_mag    = sat_to_inf ? MAG_INF : MAG_MAX;
   assign quiet_frac = {1'b1, nan_frac[HP_FRAC_W-2:0]};

   always_comb begin
      flags = '0;
      unique case (cls)
         CL_ZERO:  res = {sign, MAG_W'(0)};
         CL_INF:   res = {sign, MAG_INF};
         CL_QNAN:  res = {sign, HP_EXP_W'(HP_EXP_MAX), nan_frac};
         CL_SNAN: begin
            res           = {sign, HP_EXP_W'(HP_EXP_MAX), quiet_frac};
            flags.invalid = 1'b1;
         end
         default: begin
            res             = ovf ? {sign, ovf_mag} : {sign, mag};
            flags.overflow  = ovf;
            flags.underflow = tiny & inx & !ovf;
            flags.inexact   = inx | ovf;
         end
      endcase
   end

endmodule

// File: rtl/f2h_convert.sv
module f2h_convert
   import f2h_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] op_i,
   input  logic [1:0]  rmode_i,
   output logic [15:0] res_o,
   output logic        invalid_o,
   output logic        overflow_o,
   output logic        underflow_o,
   output logic        inexact_o
);

   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg_out
      $error("f2h_convert: REG_OUT must be 0 or 1");
   end
   if (SP_W != 32 || HP_W != 16) begin : g_bad_fmt
      $error("f2h_convert: port widths disagree with the package formats");
   end

   rmode_e                 rm;
   logic                   u_sign;
   opclass_e               u_cls;
   logic signed [EH_W-1:0] u_exp;
   logic [SIG_W-1:0]       u_sig;
   logic [HP_FRAC_W-1:0]   u_nan;
   logic [MAG_W-1:0]       r_mag;
   logic                   r_tiny, r_ovf, r_inx;
   logic [HP_W-1:0]        s_res;
   flags_t                 s_flags;

   assign rm = rmode_e'(rmode_i);

   f2h_unpack u_unpack (
      .op       (op_i),
      .sign     (u_sign),
      .cls      (u_cls),
      .exp_hp   (u_exp),
      .sig      (u_sig),
      .nan_frac (u_nan)
   );

   f2h_align_round u_round (
      .sign   (u_sign),
      .rmode  (rm),
      .exp_hp (u_exp),
      .sig    (u_sig),
      .mag    (r_mag),
      .tiny   (r_tiny),
      .ovf    (r_ovf),
      .inx    (r_inx)
   );

   f2h_select u_select (
      .sign     (u_sign),
      .cls      (u_cls),
      .rmode    (rm),
      .nan_frac (u_nan),
      .mag      (r_mag),
      .tiny     (r_tiny),
      .ovf      (r_ovf),
      .inx      (r_inx),
      .res      (s_res),
      .flags    (s_flags)
   );

   if (REG_OUT == 1) begin : g_reg
      logic [HP_W-1:0] res_q;
      flags_t          flags_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
         end else begin
            res_q   <= s_res;
            flags_q <= s_flags;
         end
      end
      assign res_o       = res_q;
      assign invalid_o   = flags_q.invalid;
      assign overflow_o  = flags_q.overflow;
      assign underflow_o = flags_q.underflow;
      assign inexact_o   = flags_q.inexact;
   end else begin : g_comb
      assign res_o       = s_res;
      assign invalid_o   = s_flags.invalid;
      assign overflow_o  = s_flags.overflow;
      assign underflow_o = s_flags.underflow;
      assign inexact_o   = s_flags.inexact;
   end

endmodule

// File: rtl/f2h_convert_chk.sv
module f2h_convert_chk #(
   parameter int REG_OUT = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] op_i,
   input logic [15:0] res_o,
   input logic        invalid_o,
   input logic        overflow_o,
   input logic        underflow_o,
   input logic        inexact_o
);

   logic [31:0] op_seen;

   if (REG_OUT == 1) begin : g_lat
      logic [31:0] op_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) op_q <= '0;
         else        op_q <= op_i;
      end
      assign op_seen = op_q;
   end else begin : g_nolat
      assign op_seen = op_i;
   end

   logic e_ones, f_zero, no_flags, res_nan;
   assign e_ones   = &op_seen[30:23];
   assign f_zero   = ~|op_seen[22:0];
   assign no_flags = !(invalid_o | overflow_o | underflow_o | inexact_o);
   assign res_nan  = (&res_o[14:10]) && (|res_o[9:0]);

   // R1
   snan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_ones && !f_zero && !op_seen[22]) |-> (invalid_o && res_o[9] && res_nan
         && !overflow_o && !underflow_o && !inexact_o));

   // R2
   qnan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_ones && op_seen[22]) |-> (res_nan && no_flags
         && res_o[9:0] == op_seen[22:13]));

   // R3
   inf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_ones && f_zero) |-> (res_o == {op_seen[31], 15'h7C00} && no_flags));

   // R4
   zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_seen[30:0] == 31'd0) |-> (res_o == {op_seen[31], 15'h0000} && no_flags));

   // R7
   ovf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> (inexact_o && (res_o[14:0] == 15'h7C00 || res_o[14:0] == 15'h7BFF)));

   // R8
   unf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |-> (inexact_o && !overflow_o && res_o[14:10] <= 5'd1));

   // R1
   invalid_only_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_o |-> (e_ones && !f_zero));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (res_o == 16'h0000 && no_flags));

endmodule

bind f2h_convert f2h_convert_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_i        (op_i),
   .res_o       (res_o),
   .invalid_o   (invalid_o),
   .overflow_o  (overflow_o),
   .underflow_o (underflow_o),
   .inexact_o   (inexact_o)
);

// File: tb/tb_f2h_convert.sv
module tb_f2h_convert;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_i = '0;
   logic [1:0]  rmode_i = '0;
   logic [15:0] res_o;
   logic        invalid_o, overflow_o, underflow_o, inexact_o;

   int n_checks = 0;
   int n_fail   = 0;

   localparam logic [1:0] RNE = 2'b00, RTZ = 2'b01, RUP = 2'b10, RDN = 2'b11;
   // flag vector order: {invalid, overflow, underflow, inexact}
   localparam logic [3:0] F_NONE = 4'b0000, F_INV = 4'b1000, F_OI = 4'b0101,
                          F_UI = 4'b0011, F_I = 4'b0001;

   always #(CLK_PERIOD/2) clk = ~clk;

   f2h_convert dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op_i),
      .rmode_i     (rmode_i),
      .res_o       (res_o),
      .invalid_o   (invalid_o),
      .overflow_o  (overflow_o),
      .underflow_o (underflow_o),
      .inexact_o   (inexact_o)
   );

   task automatic check(input string req, input logic [15:0] exp_res, input logic [3:0] exp_fl);
      logic [3:0] act_fl;
      act_fl = {invalid_o, overflow_o, underflow_o, inexact_o};
      n_checks++;
      if (res_o !== exp_res || act_fl !== exp_fl) begin
         n_fail++;
         $display("FAIL %s: res=%h flags=%b expected res=%h flags=%b",
                  req, res_o, act_fl, exp_res, exp_fl);
      end
   endtask

   // drive on a falling edge, result registered at the rising edge, sample at next falling edge
   task automatic conv(input string req, input logic [31:0] op, input logic [1:0] rm,
                       input logic [15:0] exp_res, input logic [3:0] exp_fl);
      @(negedge clk);
      op_i    = op;
      rmode_i = rm;
      @(negedge clk);
      check(req, exp_res, exp_fl);
   endtask

   task automatic t_reset;
      op_i    = 32'h3F80_0000;
      rmode_i = RUP;
      repeat (3) @(negedge clk);
      check("R10 reset", 16'h0000, F_NONE);
      rst_n = 1'b1;
   endtask

   task automatic t_specials;
      conv("R1 snan", 32'h7F80_0001, RNE, 16'h7E00, F_INV);
      conv("R1 snan payload", 32'hFFA0_0000, RTZ, 16'hFF00, F_INV);
      conv("R2 qnan", 32'h7FC0_0000, RNE, 16'h7E00, F_NONE);
      conv("R2 qnan payload", 32'h7FE0_0000, RDN, 16'h7F00, F_NONE);
      conv("R3 +inf", 32'h7F80_0000, RTZ, 16'h7C00, F_NONE);
      conv("R3 -inf", 32'hFF80_0000, RUP, 16'hFC00, F_NONE);
      conv("R4 +zero", 32'h0000_0000, RDN, 16'h0000, F_NONE);
      conv("R4 -zero", 32'h8000_0000, RUP, 16'h8000, F_NONE);
   endtask

   task automatic t_exact;
      conv("R5 one", 32'h3F80_0000, RNE, 16'h3C00, F_NONE);
      conv("R5 -2.5", 32'hC020_0000, RUP, 16'hC100, F_NONE);
      conv("R5 max finite", 32'h477F_E000, RTZ, 16'h7BFF, F_NONE);
      conv("R5 min normal", 32'h3880_0000, RNE, 16'h0400, F_NONE);
   endtask

   task automatic t_round_modes;
      // tie with even lsb
      conv("R6 tie even rne", 32'h3F80_1000, RNE, 16'h3C00, F_I);
      conv("R6 tie even rup", 32'h3F80_1000, RUP, 16'h3C01, F_I);
      conv("R6 tie even rtz", 32'h3F80_1000, RTZ, 16'h3C00, F_I);
      conv("R6 tie even rdn", 32'h3F80_1000, RDN, 16'h3C00, F_I);
      // tie with odd lsb
      conv("R6 tie odd rne", 32'h3F80_3000, RNE, 16'h3C02, F_I);
      conv("R6 tie odd rtz", 32'h3F80_3000, RTZ, 16'h3C01, F_I);
      // negative operand
      conv("R6 neg rdn", 32'hBF80_1000, RDN, 16'hBC01, F_I);
      conv("R6 neg rup", 32'hBF80_1000, RUP, 16'hBC00, F_I);
   endtask

   task automatic t_overflow;
      conv("R7 pos rne", 32'h4780_0000, RNE, 16'h7C00, F_OI);
      conv("R7 pos rtz", 32'h4780_0000, RTZ, 16'h7BFF, F_OI);
      conv("R7 pos rup", 32'h4780_0000, RUP, 16'h7C00, F_OI);
      conv("R7 pos rdn", 32'h4780_0000, RDN, 16'h7BFF, F_OI);
      conv("R7 neg rup", 32'hC780_0000, RUP, 16'hFBFF, F_OI);
      conv("R7 neg rdn", 32'hC780_0000, RDN, 16'hFC00, F_OI);
      conv("R7 round carry", 32'h477F_F000, RNE, 16'h7C00, F_OI);
      conv("R6 no carry rtz", 32'h477F_F000, RTZ, 16'h7BFF, F_I);
   endtask

   task automatic t_subnormal_out;
      conv("R8 exact min sub", 32'h3380_0000, RNE, 16'h0001, F_NONE);
      conv("R8 half min rne", 32'h3300_0000, RNE, 16'h0000, F_UI);
      conv("R8 half min rup", 32'h3300_0000, RUP, 16'h0001, F_UI);
      conv("R8 three halves", 32'h33C0_0000, RNE, 16'h0002, F_UI);
      conv("R8 round to normal", 32'h387F_FFFF, RNE, 16'h0400, F_UI);
      conv("R8 below normal rtz", 32'h387F_FFFF, RTZ, 16'h03FF, F_UI);
   endtask

   task automatic t_subnormal_in;
      conv("R9 pos rne", 32'h0000_0001, RNE, 16'h0000, F_UI);
      conv("R9 pos rup", 32'h0000_0001, RUP, 16'h0001, F_UI);
      conv("R9 neg rdn", 32'h8000_0001, RDN, 16'h8001, F_UI);
      conv("R9 neg rtz", 32'h8000_0001, RTZ, 16'h8000, F_UI);
   endtask

   task automatic t_latency;
      // R10: output holds the previous operand's result until the next edge
      @(negedge clk);
      op_i    = 32'h3F80_0000;
      rmode_i = RNE;
      @(negedge clk);
      op_i    = 32'h7F80_0000;
      #1;
      check("R10 one-cycle hold", 16'h3C00, F_NONE);
      @(negedge clk);
      check("R10 next result", 16'h7C00, F_NONE);
   endtask

   initial begin
      t_reset();
      t_specials();
      t_exact();
      t_round_modes();
      t_overflow();
      t_subnormal_out();
      t_subnormal_in();
      t_latency();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule